// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces the horizontal and vertical timing of a 320-pixel-wide raster from a 24 MHz master clock. A position counter runs across a 1536-clock scanline and a 9-bit line counter steps once per scanline. From them the block derives an active-low horizontal sync, an active-low vertical sync, a horizontal blanking strobe that tells the colour path to emit the reference colour, and a separate blanking signal that zeroes the DAC inputs. A pixel-enable pulse marks each 4-clock pixel slot.

The line counter does not run from zero. It starts at 0x0F8 after reset, steps up to 0x1FF and then wraps to 0x0F8 for the 264-line frame, or to 0x0C8 for the 312-line frame, which adds 48 blanked lines ahead of vertical sync. The 60 Hz frame blanks its 16-line borders; the 50 Hz frame shows them as picture. The current line number is brought out so that a processor-readable register can sample it. After reset is released both syncs stay low and the timing is held, so that horizontal sync first rises a fixed 1399 clocks later.

Top module: `vt_raster_timing`

## Requirements
- R1: `pix_ce` is high for one clock in every 4, on clock offsets 0, 4, 8, ... of each scanline, and stays low while the timing is held after reset.
- R2: A scanline is 1536 clocks; `hsync_n` is low for its first 112 clocks (offsets 0–111) and high for the rest.
- R3: `hblank` is high on offsets 0–223 (sync plus back porch) and 1504–1535 (front porch), and low on the 1280 active offsets 224–1503.
- R4: `line_num` is 0x0F8 in reset and steps by one on the clock where the scanline offset returns to 0, the same clock on which `hsync_n` falls.
- R5: With `pal_mode` = 0 the line number wraps from 0x1FF to 0x0F8, giving 264 lines per frame.
- R6: With `pal_mode` = 1 the line number wraps from 0x1FF to 0x0C8, giving 312 lines per frame.
- R7: `vsync_n` is low for exactly the whole lines numbered 0x0F8–0x0FF and high on every other line.
- R8: `dac_blank` (1 = blanked) takes the blanking status of the current line at scanline offset 56 and holds it until offset 56 of the next line; a line is blanked when its number is below 0x110 or at least 0x1F0 with `pal_mode` = 0, and when its number is below 0x100 with `pal_mode` = 1.
- R9: After `rst_n` goes high, `hsync_n` and `vsync_n` stay low and `hsync_n` first rises immediately after the 1399th rising clock edge seen with `rst_n` high; scanline offset 0 begins at the 1287th such edge.
- R10: While `rst_n` is low at a clock edge, outputs return to: `hsync_n` = 0, `vsync_n` = 0, `hblank` = 1, `dac_blank` = 1, `pix_ce` = 0, `line_num` = 0x0F8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pal_mode | input | 1 | 0 = 264-line frame with blanked borders, 1 = 312-line frame with shown borders |
| pix_ce | output | 1 | One-clock pulse at the start of each pixel slot |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| hblank | output | 1 | Horizontal blanking strobe, selects the reference colour |
| dac_blank | output | 1 | Line blanking, forces the DAC inputs to zero |
| line_num | output | 9 | Current line counter value |

## Verification
Every output is a register or a function of registers, so each result belongs to the cycle just after the clock edge that moved the counters; the bench counts edges since reset release, derives scanline offset and line index from that count alone and samples on the falling clock. The startup hold moves the whole raster by 1286 edges, which the reference adds before computing offsets, and the DAC blanking flag lags the line change by 56 offsets, which the reference models by looking back one line for offsets below 56. A shortened-line instance runs whole 60 Hz and 50 Hz frames through both wraps, while an instance at default parameters checks the 1399-edge start-up and the first lines at real widths.

// File: rtl/vt_pkg.sv
// Package vt_pkg
// Shared line-number landmarks and the line blanking rule of the raster
// timing generator. The 9-bit line values are fixed by behaviour: other
// logic reads the counter and decodes these ranges.
package vt_pkg;

    localparam int LINE_W = 9;

    localparam logic [LINE_W-1:0] LN_SYNC_FIRST = 9'h0F8;
    localparam logic [LINE_W-1:0] LN_SYNC_LAST  = 9'h0FF;
    localparam logic [LINE_W-1:0] LN_TOP_FIRST  = 9'h100;
    localparam logic [LINE_W-1:0] LN_PIC_FIRST  = 9'h110;
    localparam logic [LINE_W-1:0] LN_BOT_FIRST  = 9'h1F0;
    localparam logic [LINE_W-1:0] LN_LAST       = 9'h1FF;
    localparam logic [LINE_W-1:0] LN_LONG_WRAP  = 9'h0C8;

    typedef enum logic {
        FRAME_SHORT = 1'b0,
        FRAME_LONG  = 1'b1
    } frame_kind_e;

    // True when a line carries no picture for the selected frame kind.
    function automatic logic line_is_blank(input logic [LINE_W-1:0] ln,
                                           input frame_kind_e kind);
        logic below_top;
        below_top = (ln < LN_TOP_FIRST);
        if (kind == FRAME_LONG)
            return below_top;
        return (ln < LN_PIC_FIRST) || (ln >= LN_BOT_FIRST);
    endfunction

endpackage

// File: rtl/vt_startup.sv
// Module vt_startup
// Holds the raster still for HOLD_CYC edges after reset release, then
// raises run for good. Assumes HOLD_CYC >= 1 and synchronous reset.
module vt_startup #(
    parameter int HOLD_CYC = 1287
) (
    input  logic clk,
    input  logic rst_n,
    output logic run
);

    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(HOLD_CYC - 1);

    logic [CW-1:0] hold_cnt;

    // Count held edges and release the raster on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            run      <= 1'b0;
        end else if (!run) begin
            if (hold_cnt == CNT_END)
                run <= 1'b1;
            else
                hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // R9
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

endmodule

// File: rtl/vt_hcount.sv
// Module vt_hcount
// Scanline position counter in master clocks, with pixel slot pulse,
// horizontal sync, horizontal blanking and two strobes for the line
// counter and the DAC blanking register. Assumes the line length is a
// multiple of PIX_DIV and that DAC_AT lies inside the line.
module vt_hcount #(
    parameter int H_SYNC   = 112,
    parameter int H_BACK   = 112,
    parameter int H_ACTIVE = 1280,
    parameter int H_FRONT  = 32,
    parameter int PIX_DIV  = 4,
    parameter int DAC_AT   = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pix_ce,
    output logic hsync_n,
    output logic hblank,
    output logic line_end,
    output logic dac_tick
);

    localparam int H_TOTAL = H_SYNC + H_BACK + H_ACTIVE + H_FRONT;
    localparam int HW      = $clog2(H_TOTAL);
    localparam logic [HW-1:0] POS_LAST   = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] SYNC_END   = HW'(H_SYNC);
    localparam logic [HW-1:0] PIC_START  = HW'(H_SYNC + H_BACK);
    localparam logic [HW-1:0] PIC_END    = HW'(H_SYNC + H_BACK + H_ACTIVE);
    localparam logic [HW-1:0] DAC_BEFORE = HW'(DAC_AT - 1);

    logic [HW-1:0] hpos;

    // Advance the scanline position while running, wrapping at line end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hpos <= '0;
        else if (run)
            hpos <= (hpos == POS_LAST) ? '0 : hpos + 1'b1;
    end

    // Strobes consumed by neighbours on the next edge.
    always_comb begin
        line_end = run && (hpos == POS_LAST);
        dac_tick = run && (hpos == DAC_BEFORE);
    end

    // Sync and blanking windows decoded from the position.
    always_comb begin
        hsync_n = (hpos >= SYNC_END);
        hblank  = (hpos < PIC_START) || (hpos >= PIC_END);
    end

    generate
        if (PIX_DIV > 1) begin : g_div
            localparam int PW = $clog2(PIX_DIV);
            localparam logic [PW-1:0] PH_LAST = PW'(PIX_DIV - 1);
            logic [PW-1:0] phase;

            // Pixel phase, restarted at each line so slots align to offset 0.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    phase <= '0;
                else if (run)
                    phase <= (phase == PH_LAST || hpos == POS_LAST) ? '0 : phase + 1'b1;
            end

            // Slot pulse on phase zero.
            always_comb pix_ce = run && (phase == '0);

            // R1
            pix_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pix_ce |=> !pix_ce);
        end else begin : g_nodiv
            // Every clock is a pixel when the divider is one.
            always_comb pix_ce = run;
        end
    endgenerate

    // R3
    hsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> hblank);

    // R2
    sync_starts_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> !hsync_n);

endmodule

// File: rtl/vt_vcount.sv
// Module vt_vcount
// Offset 9-bit line counter with frame-kind dependent wrap point,
// vertical sync decode and line blanking status. Assumes step pulses
// arrive once per scanline from the position counter.
module vt_vcount
    import vt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  frame_kind_e       kind,
    output logic [LINE_W-1:0] line,
    output logic              vsync_n,
    output logic              line_blank
);

    logic [LINE_W-1:0] wrap_to;

    // Wrap target chosen by the frame kind.
    always_comb wrap_to = (kind == FRAME_LONG) ? LN_LONG_WRAP : LN_SYNC_FIRST;

    // Step the line on each scanline boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line <= LN_SYNC_FIRST;
        else if (step)
            line <= (line == LN_LAST) ? wrap_to : line + 1'b1;
    end

    // Vertical sync window and blanking status of the current line.
    always_comb begin
        vsync_n    = !((line >= LN_SYNC_FIRST) && (line <= LN_SYNC_LAST));
        line_blank = line_is_blank(line, kind);
    end

    // R4
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && (line != LN_LAST) |=> line == $past(line) + 9'd1);

    // R5
    short_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && (line == LN_LAST) && (kind == FRAME_SHORT) |=> line == LN_SYNC_FIRST);

    // R6
    long_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && (line == LN_LAST) && (kind == FRAME_LONG) |=> line == LN_LONG_WRAP);

    // R7
    vsync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> line == LN_SYNC_FIRST);

endmodule

// File: rtl/vt_raster_timing.sv
// Module vt_raster_timing
// Top of the raster timing generator: start-up hold, scanline position,
// line counter and the DAC blanking register that samples the line
// blanking status part way through the back porch. Assumes
// START_DLY > H_SYNC + 1 and DAC_AT within the line.
module vt_raster_timing
    import vt_pkg::*;
#(
    parameter int H_SYNC    = 112,
    parameter int H_BACK    = 112,
    parameter int H_ACTIVE  = 1280,
    parameter int H_FRONT   = 32,
    parameter int PIX_DIV   = 4,
    parameter int DAC_AT    = 56,
    parameter int START_DLY = 1399
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pal_mode,
    output logic       pix_ce,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic       hblank,
    output logic       dac_blank,
    output logic [8:0] line_num
);

    localparam int HOLD_CYC = START_DLY - H_SYNC;

    logic        run;
    logic        line_end;
    logic        dac_tick;
    logic        line_blank;
    frame_kind_e kind;

    // Frame kind from the mode pin.
    always_comb kind = pal_mode ? FRAME_LONG : FRAME_SHORT;

    vt_startup #(
        .HOLD_CYC (HOLD_CYC)
    ) i_startup (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run)
    );

    vt_hcount #(
        .H_SYNC   (H_SYNC),
        .H_BACK   (H_BACK),
        .H_ACTIVE (H_ACTIVE),
        .H_FRONT  (H_FRONT),
        .PIX_DIV  (PIX_DIV),
        .DAC_AT   (DAC_AT)
    ) i_hcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .pix_ce   (pix_ce),
        .hsync_n  (hsync_n),
        .hblank   (hblank),
        .line_end (line_end),
        .dac_tick (dac_tick)
    );

    vt_vcount i_vcount (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (line_end),
        .kind       (kind),
        .line       (line_num),
        .vsync_n    (vsync_n),
        .line_blank (line_blank)
    );

    // Latch the line blanking status at the back-porch sample point.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dac_blank <= 1'b1;
        else if (dac_tick)
            dac_blank <= line_blank;
    end

    // R8
    dac_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_blank != $past(dac_blank)) |-> $past(dac_tick));

    // R9
    held_sync_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!hsync_n && !vsync_n));

    // R2
    line_end_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |-> (hblank && hsync_n));

endmodule

// File: tb/test_vt_raster_timing.sv
// Bench for vt_raster_timing: a behavioural reference derived from the
// number of edges since reset release, compared on every falling clock
// against a shortened-line instance and a default-parameter instance.
module test_vt_raster_timing;

    localparam int S_HS = 8, S_HB = 8, S_HA = 16, S_HF = 4, S_DE = 4, S_SD = 20;
    localparam int F_HS = 112, F_HB = 112, F_HA = 1280, F_HF = 32, F_DE = 56, F_SD = 1399;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pal_mode = 1'b0;

    logic       s_pix, s_hs, s_vs, s_hb, s_dac;
    logic [8:0] s_line;
    logic       f_pix, f_hs, f_vs, f_hb, f_dac;
    logic [8:0] f_line;

    int vectors = 0;
    int misses = 0;
    int k = -1;
    int cyc = 0;
    bit checking = 1'b0;
    bit done = 1'b0;
    int first_rise = -1;

    always #4 clk = ~clk;

    vt_raster_timing #(
        .H_SYNC (S_HS), .H_BACK (S_HB), .H_ACTIVE (S_HA), .H_FRONT (S_HF),
        .PIX_DIV (4), .DAC_AT (S_DE), .START_DLY (S_SD)
    ) i_vt_raster_timing (
        .clk (clk), .rst_n (rst_n), .pal_mode (pal_mode),
        .pix_ce (s_pix), .hsync_n (s_hs), .vsync_n (s_vs),
        .hblank (s_hb), .dac_blank (s_dac), .line_num (s_line)
    );

    vt_raster_timing i_vt_raster_timing_full (
        .clk (clk), .rst_n (rst_n), .pal_mode (pal_mode),
        .pix_ce (f_pix), .hsync_n (f_hs), .vsync_n (f_vs),
        .hblank (f_hb), .dac_blank (f_dac), .line_num (f_line)
    );

    // Edges seen with reset released; -1 while in reset.
    always @(posedge clk) begin
        k <= rst_n ? k + 1 : -1;
        cyc <= cyc + 1;
    end

    function automatic int line_of(input int idx, input bit pal);
        if (!pal) return 'h0F8 + (idx % 264);
        if (idx < 264) return 'h0F8 + idx;
        return 'h0C8 + ((idx - 264) % 312);
    endfunction

    function automatic bit blank_of(input int ln, input bit pal);
        if (pal) return ln < 'h100;
        return (ln < 'h110) || (ln >= 'h1F0);
    endfunction

    task automatic cmp(input string tag, input string name, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s at edge %0d: actual %0h expected %0h", tag, name, k, act, exp);
        end
    endtask

    task automatic check_inst(input string who, input int hs, hb, ha, hf, de, sd,
                              input bit pal, input logic pix, hsn, vsn, hbl, dac,
                              input logic [8:0] ln);
        int hold, total, h, idx, v;
        bit e_pix, e_hs, e_vs, e_hb, e_dac;
        string t_hs, t_ln;
        hold  = sd - hs - 1;
        total = hs + hb + ha + hf;
        if (k < hold) begin h = 0; idx = 0; end
        else begin h = (k - hold) % total; idx = (k - hold) / total; end
        v     = line_of(idx, pal);
        e_pix = (k >= hold) && (h % 4 == 0);
        e_hs  = (h >= hs);
        e_hb  = (h < hs + hb) || (h >= hs + hb + ha);
        e_vs  = !((v >= 'h0F8) && (v <= 'h0FF));
        if (h >= de) e_dac = blank_of(v, pal);
        else if (idx == 0) e_dac = 1'b1;
        else e_dac = blank_of(line_of(idx - 1, pal), pal);
        t_hs = (k < 0) ? "R10" : ((k < sd) ? "R9" : "R2");
        t_ln = (k < 0) ? "R10" : (idx < 264 ? "R4" : (pal ? "R6" : "R5"));
        cmp((k < 0) ? "R10" : "R1", {who, " pix_ce"}, int'(pix), int'(e_pix));
        cmp(t_hs, {who, " hsync_n"}, int'(hsn), int'(e_hs));
        cmp((k < 0) ? "R10" : "R7", {who, " vsync_n"}, int'(vsn), int'(e_vs));
        cmp((k < 0) ? "R10" : "R3", {who, " hblank"}, int'(hbl), int'(e_hb));
        cmp((k < 0) ? "R10" : "R8", {who, " dac_blank"}, int'(dac), int'(e_dac));
        cmp(t_ln, {who, " line_num"}, int'(ln), v);
    endtask

    // Compare both instances away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            check_inst("short", S_HS, S_HB, S_HA, S_HF, S_DE, S_SD, pal_mode,
                       s_pix, s_hs, s_vs, s_hb, s_dac, s_line);
            check_inst("full", F_HS, F_HB, F_HA, F_HF, F_DE, F_SD, pal_mode,
                       f_pix, f_hs, f_vs, f_hb, f_dac, f_line);
            if (first_rise < 0 && k >= 0 && f_hs === 1'b1) first_rise = k;
        end
    end

    task automatic run_mode(input bit pal, input int edges);
        checking = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        pal_mode = pal;
        first_rise = -1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        checking = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (edges) @(posedge clk);
        @(negedge clk);
        // R9: first rise of the full-width sync right after the 1399th edge
        vectors++;
        if (first_rise != F_SD - 1) begin
            misses++;
            $display("FAIL R9 first hsync_n rise: actual edge %0d expected edge %0d",
                     first_rise, F_SD - 1);
        end
    endtask

    initial begin
        // Short-frame run: two full frames plus a few lines (R5 wrap).
        run_mode(1'b0, 264 * 36 * 2 + 200);
        // Long-frame run: start segment, one full long frame, into the next (R6 wrap).
        run_mode(1'b1, (264 + 312 + 20) * 36 + 100);
        checking = 1'b0;
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: an overrun is a failed check.
    always @(posedge clk) begin
        if (!done && cyc > 190000) begin
            misses++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule